// File: doc/BRIEF.md
# Processor Operating Mode Controller

This block keeps track of the operating mode a processor core is running in: real-address, protected, virtual-8086, long (split into a 64-bit and a compatibility sub-mode) and system-management. The rest of the core drives it with the current values of its mode-control bits: protection enable, paging enable, long-mode enable, the virtual-8086 flag and the long bit of the code segment. It also receives a system-management interrupt request and a resume strobe. From these the controller derives a one-hot mode vector, a long-mode-active flag and a sub-mode flag. All outputs are registered.

Entry to system-management mode is allowed from every other mode. The mode that was interrupted is held in a saved-mode register, and the resume strobe restores exactly that mode. Long mode can only be reached from protected mode, and only while long-mode enable and paging enable are both set. Saving the processor context, switching the address space and executing instructions are handled elsewhere.

Top module: `opmode_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller into real-address mode from any mode, including system-management mode, with `long_active` and `long64` low.
- R2: `mode_oh` always has exactly one bit set: bit 0 real-address, bit 1 protected, bit 2 virtual-8086, bit 3 long, bit 4 system-management.
- R3: In real-address mode, `prot_en`=1 selects protected mode. In protected, virtual-8086 or long mode, `prot_en`=0 selects real-address mode. Outputs change on the first clock edge that samples the triggering input.
- R4: In protected mode, with `long_en` and `paging_en` not both set, `v86_flag`=1 selects virtual-8086 mode. In virtual-8086 mode with `prot_en`=1, `v86_flag`=0 selects protected mode.
- R5: Long mode is entered only from protected mode, when `prot_en`, `long_en` and `paging_en` are all 1. This takes priority over `v86_flag`. Clearing `long_en` or `paging_en` in long mode selects protected mode if `prot_en`=1 and real-address mode otherwise.
- R6: `long_active` is high exactly while the mode is long. `long64` equals `cs_long` as sampled on the same edge while the mode is long, and is 0 in every other mode.
- R7: `smi_req`=1 outside system-management mode selects system-management mode on the next edge, from every mode. This takes priority over all mode-control bits.
- R8: `rsm_req`=1 in system-management mode restores exactly the mode held at entry, whatever the mode-control bits are at that time.
- R9: In system-management mode, `smi_req` and all mode-control bits have no effect. Outside it, `rsm_req` has no effect.
- R10: In long mode, `v86_flag`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req | input | 1 | System-management interrupt request |
| rsm_req | input | 1 | Resume-from-management strobe |
| prot_en | input | 1 | Protection-enable bit |
| paging_en | input | 1 | Paging-enable bit |
| long_en | input | 1 | Long-mode-enable bit |
| v86_flag | input | 1 | Virtual-8086 flag |
| cs_long | input | 1 | Code-segment long bit |
| mode_oh | output | 5 | One-hot current mode |
| long_active | output | 1 | Long mode active |
| long64 | output | 1 | 1 = 64-bit sub-mode, 0 = compatibility (only in long mode) |

## Verification
The directed walks visit every mode. Some enter system management from each mode and resume, which shows whether the saved mode or the live control bits decide where the controller returns. Some raise the interrupt request on the same edge as a control-bit change, and one toggles the virtual-8086 flag while paging is enabled. These cases separate the priority orderings from one another. A long randomised stretch, with sparse resets, interrupts and resume strobes, then mixes all of these, while a behavioural model in the bench predicts every output on every cycle.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int MODE_N = 5;

  typedef enum logic [MODE_N-1:0] {
    MD_REAL = 5'b00001,
    MD_PROT = 5'b00010,
    MD_V86  = 5'b00100,
    MD_LONG = 5'b01000,
    MD_SMM  = 5'b10000
  } mode_e;
endpackage

// File: rtl/opmode_next.sv
module opmode_next
  import opmode_pkg::*;
(
  input  mode_e cur,
  input  mode_e saved,
  input  logic  smi_req,
  input  logic  rsm_req,
  input  logic  prot_en,
  input  logic  paging_en,
  input  logic  long_en,
  input  logic  v86_flag,
  output mode_e nxt,
  output logic  save_en
);
  logic long_ok;
  assign long_ok = long_en && paging_en;

  always_comb begin
    nxt     = cur;
    save_en = 1'b0;
    if (cur == MD_SMM) begin
      if (rsm_req) nxt = saved;
    end else if (smi_req) begin
      nxt     = MD_SMM;
      save_en = 1'b1;
    end else begin
      case (cur)
        MD_REAL: if (prot_en) nxt = MD_PROT;
        MD_PROT: begin
          if (!prot_en)     nxt = MD_REAL;
          else if (long_ok) nxt = MD_LONG;
          else if (v86_flag) nxt = MD_V86;
        end
        MD_V86: begin
          if (!prot_en)      nxt = MD_REAL;
          else if (!v86_flag) nxt = MD_PROT;
        end
        MD_LONG: begin
          if (!prot_en)      nxt = MD_REAL;
          else if (!long_ok) nxt = MD_PROT;
        end
        default: nxt = MD_REAL;
      endcase
    end
  end
endmodule

// File: rtl/opmode_save.sv
module opmode_save
  import opmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  save_en,
  input  mode_e cur,
  output mode_e saved
);
  always_ff @(posedge clk) begin
    if (rst)          saved <= MD_REAL;
    else if (save_en) saved <= cur;
  end
endmodule

// File: rtl/opmode_sub.sv
module opmode_sub
  import opmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e nxt,
  input  logic  cs_long,
  output logic  long_active,
  output logic  long64
);
  always_ff @(posedge clk) begin
    if (rst) begin
      long_active <= 1'b0;
      long64      <= 1'b0;
    end else begin
      long_active <= (nxt == MD_LONG);
      long64      <= (nxt == MD_LONG) && cs_long;
    end
  end
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              smi_req,
  input  logic              rsm_req,
  input  logic              prot_en,
  input  logic              paging_en,
  input  logic              long_en,
  input  logic              v86_flag,
  input  logic              cs_long,
  output logic [MODE_N-1:0] mode_oh,
  output logic              long_active,
  output logic              long64
);
  mode_e mode_q;
  mode_e mode_d;
  mode_e saved_q;
  logic  save_en;

  opmode_next u_next (
    .cur(mode_q), .saved(saved_q), .smi_req(smi_req), .rsm_req(rsm_req),
    .prot_en(prot_en), .paging_en(paging_en), .long_en(long_en),
    .v86_flag(v86_flag), .nxt(mode_d), .save_en(save_en)
  );

  opmode_save u_save (
    .clk(clk), .rst(rst), .save_en(save_en), .cur(mode_q), .saved(saved_q)
  );

  opmode_sub u_sub (
    .clk(clk), .rst(rst), .nxt(mode_d), .cs_long(cs_long),
    .long_active(long_active), .long64(long64)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MD_REAL;
    else     mode_q <= mode_d;
  end

  assign mode_oh = mode_q;
endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       smi_req,
  input logic       rsm_req,
  input logic       prot_en,
  input logic       paging_en,
  input logic       long_en,
  input logic       v86_flag,
  input logic [4:0] mode_oh,
  input logic       long_active,
  input logic       long64
);
  logic       in_smm;
  logic [4:0] chk_saved;
  assign in_smm = mode_oh[4];

  always_ff @(posedge clk) begin
    if (rst) chk_saved <= 5'b00001;
    else if (smi_req && !in_smm) chk_saved <= mode_oh;
  end

  AST_RESET_REAL: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_oh == 5'b00001 && !long_active && !long64)); // R1
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_oh) == 1); // R2
  AST_LONG_FROM_PROT: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_oh[3]) |-> ($past(mode_oh) == 5'b00010 || $past(mode_oh) == 5'b10000)); // R5
  AST_LONG_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    (long_active == mode_oh[3]) && (long64 -> long_active)); // R6
  AST_SMI_ENTER: assert property (@(posedge clk) disable iff (rst)
    (smi_req && !in_smm) |=> in_smm); // R7
  AST_RESUME_EXACT: assert property (@(posedge clk) disable iff (rst)
    (in_smm && rsm_req) |=> (mode_oh == chk_saved)); // R8
  AST_SMM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_smm && !rsm_req) |=> in_smm); // R9
  AST_LONG_NO_V86: assert property (@(posedge clk) disable iff (rst)
    (mode_oh[3] && prot_en && paging_en && long_en && !smi_req) |=> mode_oh[3]); // R10
endmodule

bind opmode_ctrl opmode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .smi_req(smi_req), .rsm_req(rsm_req),
  .prot_en(prot_en), .paging_en(paging_en), .long_en(long_en),
  .v86_flag(v86_flag), .mode_oh(mode_oh), .long_active(long_active),
  .long64(long64)
);

// File: tb/opmode_ctrl_tb.sv
module opmode_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smi_req = 0, rsm_req = 0, prot_en = 0, paging_en = 0;
  logic long_en = 0, v86_flag = 0, cs_long = 0;
  logic [4:0] mode_oh;
  logic long_active, long64;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  // reference model state: 0 real, 1 prot, 2 v86, 3 long, 4 smm
  int    m = 0;
  int    sv = 0;
  bit    e_la = 0, e_64 = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  opmode_ctrl u_dut (
    .clk(clk), .rst(rst), .smi_req(smi_req), .rsm_req(rsm_req),
    .prot_en(prot_en), .paging_en(paging_en), .long_en(long_en),
    .v86_flag(v86_flag), .cs_long(cs_long), .mode_oh(mode_oh),
    .long_active(long_active), .long64(long64)
  );

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m = 0; sv = 0; tag = "R1";
    end else if (m == 4) begin
      if (rsm_req) begin m = sv; tag = "R8"; end
      else tag = "R9";
    end else if (smi_req) begin
      sv = m; m = 4; tag = "R7";
    end else begin
      case (m)
        0: begin tag = "R3"; if (prot_en) m = 1; end
        1: begin
          if (!prot_en) begin m = 0; tag = "R3"; end
          else if (long_en && paging_en) begin m = 3; tag = "R5"; end
          else if (v86_flag) begin m = 2; tag = "R4"; end
          else tag = "R4";
        end
        2: begin
          tag = "R4";
          if (!prot_en) m = 0;
          else if (!v86_flag) m = 1;
        end
        default: begin
          if (!prot_en) begin m = 0; tag = "R3"; end
          else if (!(long_en && paging_en)) begin m = 1; tag = "R5"; end
          else tag = "R10";
        end
      endcase
    end
    e_la = (m == 3);
    e_64 = (m == 3) && cs_long;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (mode_oh !== 5'(1 << m) || long_active !== e_la || long64 !== e_64) begin
        fails++;
        $display("FAIL %s: mode=%b la=%b l64=%b expected mode=%b la=%b l64=%b",
                 tag, mode_oh, long_active, long64, 5'(1 << m), e_la, e_64);
      end
    end
  end

  task automatic drive(input bit pe, pg, le, vm, cl, smi, rsm, input int n);
    @(negedge clk);
    prot_en = pe; paging_en = pg; long_en = le; v86_flag = vm;
    cs_long = cl; smi_req = smi; rsm_req = rsm;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic expect_mode(input logic [4:0] exp, input string req);
    @(negedge clk);
    #1;
    checks++;
    if (mode_oh !== exp) begin
      fails++;
      $display("FAIL %s: mode=%b expected %b", req, mode_oh, exp);
    end
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_mode(5'b00001, "R1");        // reset state
    rst = 0;
    drive(1,0,0,0,0,0,0,2);             // R3 real -> prot
    expect_mode(5'b00010, "R3");
    drive(1,0,0,0,0,0,1,2);             // R9 resume outside smm ignored
    expect_mode(5'b00010, "R9");
    drive(1,0,0,1,0,0,0,2);             // R4 prot -> v86
    expect_mode(5'b00100, "R4");
    drive(1,0,0,1,0,1,0,1);             // R7 smi from v86
    drive(0,1,1,0,1,1,0,3);             // R9 bits and smi ignored in smm
    expect_mode(5'b10000, "R9");
    drive(0,1,1,0,1,0,1,1);             // R8 resume to v86 despite bits
    drive(1,0,0,1,0,0,0,1);
    expect_mode(5'b00100, "R8");
    drive(1,0,0,0,0,0,0,2);             // v86 -> prot
    drive(1,1,1,1,1,0,0,2);             // R5 long has priority over vm
    expect_mode(5'b01000, "R5");
    drive(1,1,1,1,0,0,0,3);             // R10 vm ignored, R6 compat sub-mode
    expect_mode(5'b01000, "R10");
    drive(1,1,1,0,1,1,0,1);             // smi from long
    drive(0,0,0,0,1,0,0,2);
    drive(0,0,0,0,1,0,1,1);             // R8 resume to long
    drive(1,1,1,0,1,0,0,1);
    expect_mode(5'b01000, "R8");
    drive(1,0,1,0,1,0,0,2);             // R5 paging off -> prot
    expect_mode(5'b00010, "R5");
    drive(0,0,0,0,0,0,0,2);             // R3 prot -> real
    drive(1,0,0,0,0,1,0,1);             // R7 smi beats pe in same cycle
    drive(1,0,0,0,0,0,0,2);
    expect_mode(5'b10000, "R7");
    rst = 1;                             // R1 reset out of smm
    drive(1,0,0,0,0,0,0,2);
    expect_mode(5'b00001, "R1");
    rst = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rst       = ($urandom_range(0, 199) == 0);
      prot_en   = ($urandom_range(0, 9) != 0);
      paging_en = ($urandom_range(0, 3) != 0);
      long_en   = ($urandom_range(0, 2) != 0);
      v86_flag  = ($urandom_range(0, 2) == 0);
      cs_long   = $urandom_range(0, 1) != 0;
      smi_req   = ($urandom_range(0, 29) == 0);
      rsm_req   = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk);
    rst = 0; smi_req = 0; rsm_req = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule